// File: doc/BRIEF.md
# Mesochronous Link Flit Reader

This block is the receiving end of a point-to-point link whose two sides run at the same clock frequency. The phase between the two clocks is not known and can be off by up to half a period either way. The sender presents one 34-bit link word per cycle with a valid flag in its own clock domain. The block writes each valid word into a small dual-clock FIFO. The FIFO passes its pointers across the domain boundary as Gray codes through flop synchronizers.

On the receiving side, a free-running slot counter divides the local clock into slots of three cycles. The FIFO is examined for a waiting word only at the first cycle of a slot. If a word is waiting, the reader takes that word and the two words behind it in the next two cycles. It presents all three to the downstream router or network interface with a valid strobe. A word that arrives in the middle of a slot waits until the next slot opens, so every flit leaves aligned to the reader's own slot grid.

Two sticky flags report a write that found the FIFO full and a started flit that ran out of words.

Top module: `meso_flit_rx`

## Requirements
- R1: Each link word is 34 bits wide: a 32-bit payload in bits 31:0 and 2 control bits in bits 33:32. All 34 bits reach `rx_word` unchanged, in the order they were written.
- R2: The slot counter advances 0, 1, 2, 0, … on every reader clock edge after reset, whether or not traffic is present. Every flit's first word therefore appears on `rx_word` a whole number of 3-cycle slots after any earlier flit's first word.
- R3: Once the first word of a flit is taken, the second and third words appear on `rx_valid`/`rx_word` in the two cycles directly after it, with no gap.
- R4: A new flit is taken only when the slot counter is at 0. A word that arrives while the counter is at 1 or 2 stays in the FIFO until the next slot 0.
- R5: If the FIFO is empty at slot 0, `rx_valid` stays low for all three cycles of that slot.
- R6: A write while the FIFO holds DEPTH words is dropped, and `err_overflow` is set. The flag stays set until the write-side reset.
- R7: If a started flit finds the FIFO empty in slot 1 or 2, `rx_valid` is low in that cycle and `err_underflow` is set. The flag stays set until the read-side reset.
- R8: Both resets are asynchronous and active low. While reset is applied and after it is released, `rx_valid`, `err_overflow` and `err_underflow` are 0 until traffic or an error occurs.
- R9: The FIFO stores exactly DEPTH (default 8) words. With the reader held in reset, the first DEPTH writes are kept and are later delivered in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Sender-side clock |
| wr_rst_n | input | 1 | Sender-side asynchronous reset, active low |
| wr_valid | input | 1 | Link word present this write cycle |
| wr_word | input | 34 | Link word: control in 33:32, payload in 31:0 |
| rd_clk | input | 1 | Receiver-side clock, same frequency as wr_clk |
| rd_rst_n | input | 1 | Receiver-side asynchronous reset, active low |
| rx_valid | output | 1 | Word on rx_word is valid this cycle |
| rx_word | output | 34 | Word delivered to the downstream component |
| err_overflow | output | 1 | Sticky: a write found the FIFO full (write domain) |
| err_underflow | output | 1 | Sticky: a started flit ran short of words (read domain) |

## Verification
The hardest states to reach are a full FIFO and a flit cut short. At equal clock rates the reader drains words as fast as they can arrive, so neither state occurs in normal traffic. The stimulus reaches both by holding only the read-side reset while the sender writes one word more than the FIFO depth. The reader is then released. Eight words is not a multiple of three, so the third flit is left one word short. Random flits with random idle gaps enter the FIFO at every phase relative to the slot grid, and this exercises the rule that a new flit may start only at slot 0.

// File: rtl/meso_rx_pkg.sv
package meso_rx_pkg;

   localparam int DEF_DATA_W      = 32;
   localparam int DEF_CTRL_W      = 2;
   localparam int DEF_DEPTH       = 8;
   localparam int DEF_FLIT_WORDS  = 3;
   localparam int DEF_SYNC_STAGES = 2;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/meso_rx_sync.sv
module meso_rx_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("meso_rx_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/meso_rx_fifo.sv
module meso_rx_fifo #(
   parameter int WORD_W      = 34,
   parameter int DEPTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wr_clk,
   input  logic              wr_rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   output logic              ovf_flag,
   input  logic              rd_clk,
   input  logic              rd_rst_n,
   input  logic              pop,
   output logic              empty,
   output logic [WORD_W-1:0] rd_data
);

   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;
   localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

   if (!meso_rx_pkg::is_pow2(DEPTH) || DEPTH < 4) begin : g_bad_depth
      $error("meso_rx_fifo: DEPTH must be a power of two, at least 4");
   end

   logic [WORD_W-1:0] mem [DEPTH];

   logic [PW-1:0] wbin_q, wgray_q, rbin_q, rgray_q;
   logic [PW-1:0] rgray_s, wgray_s, rbin_s;
   logic          full, ovf_q;

   // write domain
   assign full = (wgray_q == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});

   always_ff @(posedge wr_clk or negedge wr_rst_n) begin
      if (!wr_rst_n) begin
         wbin_q  <= '0;
         wgray_q <= '0;
         ovf_q   <= 1'b0;
      end else if (wr_en) begin
         if (full) begin
            ovf_q <= 1'b1;
         end else begin
            wbin_q  <= wbin_q + 1'b1;
            wgray_q <= (wbin_q + 1'b1) ^ ((wbin_q + 1'b1) >> 1);
         end
      end
   end

   always_ff @(posedge wr_clk) begin
      if (wr_en && !full) mem[wbin_q[AW-1:0]] <= wr_data;
   end

   assign ovf_flag = ovf_q;

   meso_rx_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_rptr_sync (
      .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray_q), .q(rgray_s));

   always_comb begin
      for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
   end

   // read domain
   meso_rx_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_wptr_sync (
      .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray_q), .q(wgray_s));

   assign empty   = (rgray_q == wgray_s);
   assign rd_data = mem[rbin_q[AW-1:0]];

   always_ff @(posedge rd_clk or negedge rd_rst_n) begin
      if (!rd_rst_n) begin
         rbin_q  <= '0;
         rgray_q <= '0;
      end else if (pop) begin
         rbin_q  <= rbin_q + 1'b1;
         rgray_q <= (rbin_q + 1'b1) ^ ((rbin_q + 1'b1) >> 1);
      end
   end

   assert_pop_nonempty_R3: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      pop |-> !empty);

   assert_fill_bound_R9: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      (wbin_q - rbin_s) <= DEPTH_P);

   assert_sticky_ovf_R6: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      ovf_q |=> ovf_q);

endmodule

// File: rtl/meso_rx_slot_reader.sv
module meso_rx_slot_reader #(
   parameter int WORD_W     = 34,
   parameter int FLIT_WORDS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              empty,
   input  logic [WORD_W-1:0] rd_data,
   output logic              pop,
   output logic              rx_valid,
   output logic [WORD_W-1:0] rx_word,
   output logic              unf_flag
);

   localparam int SLOT_W = $clog2(FLIT_WORDS);
   localparam logic [SLOT_W-1:0] SLOT_FIRST = '0;
   localparam logic [SLOT_W-1:0] SLOT_LAST  = SLOT_W'(FLIT_WORDS - 1);

   if (FLIT_WORDS < 2) begin : g_bad_flit
      $error("meso_rx_slot_reader: FLIT_WORDS must be at least 2");
   end

   logic [SLOT_W-1:0] slot_q;
   logic              active_q, active_n;
   logic              short_hit;
   logic              valid_q, unf_q;
   logic [WORD_W-1:0] word_q;

   always_comb begin
      if (slot_q == SLOT_FIRST) begin
         pop      = !empty;
         active_n = !empty;
      end else begin
         pop      = active_q && !empty;
         active_n = (slot_q == SLOT_LAST) ? 1'b0 : active_q;
      end
      short_hit = (slot_q != SLOT_FIRST) && active_q && empty;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q   <= SLOT_FIRST;
         active_q <= 1'b0;
         valid_q  <= 1'b0;
         word_q   <= '0;
         unf_q    <= 1'b0;
      end else begin
         slot_q   <= (slot_q == SLOT_LAST) ? SLOT_FIRST : slot_q + 1'b1;
         active_q <= active_n;
         valid_q  <= pop;
         if (pop)       word_q <= rd_data;
         if (short_hit) unf_q  <= 1'b1;
      end
   end

   assign rx_valid = valid_q;
   assign rx_word  = word_q;
   assign unf_flag = unf_q;

   assert_slot_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_q == SLOT_LAST) |=> (slot_q == SLOT_FIRST));

   assert_slot_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_q != SLOT_LAST) |=> (slot_q == $past(slot_q) + 1'b1));

   assert_no_midslot_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((slot_q != SLOT_FIRST) && !active_q) |-> !pop);

   assert_sticky_unf_R7: assert property (@(posedge clk) disable iff (!rst_n)
      unf_q |=> unf_q);

endmodule

// File: rtl/meso_flit_rx.sv
module meso_flit_rx #(
   parameter int DATA_W      = meso_rx_pkg::DEF_DATA_W,
   parameter int CTRL_W      = meso_rx_pkg::DEF_CTRL_W,
   parameter int DEPTH       = meso_rx_pkg::DEF_DEPTH,
   parameter int FLIT_WORDS  = meso_rx_pkg::DEF_FLIT_WORDS,
   parameter int SYNC_STAGES = meso_rx_pkg::DEF_SYNC_STAGES
) (
   input  logic                     wr_clk,
   input  logic                     wr_rst_n,
   input  logic                     wr_valid,
   input  logic [DATA_W+CTRL_W-1:0] wr_word,
   input  logic                     rd_clk,
   input  logic                     rd_rst_n,
   output logic                     rx_valid,
   output logic [DATA_W+CTRL_W-1:0] rx_word,
   output logic                     err_overflow,
   output logic                     err_underflow
);

   localparam int WORD_W = DATA_W + CTRL_W;

   if (DEPTH < FLIT_WORDS) begin : g_bad_ratio
      $error("meso_flit_rx: DEPTH must hold at least one flit");
   end

   logic              pop, empty;
   logic [WORD_W-1:0] rd_data;

   meso_rx_fifo #(
      .WORD_W(WORD_W), .DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)
   ) u_fifo (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_valid), .wr_data(wr_word),
      .ovf_flag(err_overflow),
      .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .pop(pop), .empty(empty), .rd_data(rd_data)
   );

   meso_rx_slot_reader #(
      .WORD_W(WORD_W), .FLIT_WORDS(FLIT_WORDS)
   ) u_reader (
      .clk(rd_clk), .rst_n(rd_rst_n), .empty(empty), .rd_data(rd_data),
      .pop(pop), .rx_valid(rx_valid), .rx_word(rx_word), .unf_flag(err_underflow)
   );

endmodule

// File: tb/meso_flit_rx_bench.sv
`timescale 1ns/1ps
module meso_flit_rx_bench;

   logic        wr_clk = 1'b0, rd_clk = 1'b0;
   logic        wr_rst_n = 1'b0, rd_rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic [33:0] wr_word = '0;
   logic        rx_valid, err_overflow, err_underflow;
   logic [33:0] rx_word;

   int checks = 0, errors = 0;
   logic [33:0] exp_q [$];
   int  run = 0, cyc = 0, s0 = -1, vcount = 0;
   bit  allow_short = 1'b0;

   meso_flit_rx u_meso_flit_rx (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_word(wr_word),
      .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rx_valid(rx_valid), .rx_word(rx_word),
      .err_overflow(err_overflow), .err_underflow(err_underflow));

   initial forever #2.5 rd_clk = ~rd_clk;
   initial begin #1.7; forever #2.5 wr_clk = ~wr_clk; end

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [33:0] rand_word();
      return {2'($urandom), 32'($urandom)};
   endfunction

   // read-side monitor: order, slot alignment, no gaps
   always @(negedge rd_clk) begin
      if (!rd_rst_n) begin
         run = 0; cyc = 0; s0 = -1;
      end else begin
         cyc++;
         if (rx_valid) begin
            vcount++;
            if (run == 3) run = 0;
            if (run == 0) begin
               if (s0 < 0) s0 = cyc;
               else check(((cyc - s0) % 3) == 0, "R2 flit start off slot grid", 64'(cyc - s0), 64'(0));
            end
            run++;
            if (exp_q.size() == 0) check(1'b0, "R1 unexpected word", 64'(rx_word), 64'(0));
            else begin
               logic [33:0] e;
               e = exp_q.pop_front();
               check(rx_word == e, "R1 word mismatch", 64'(rx_word), 64'(e));
            end
         end else if (run != 0) begin
            if (!allow_short) check(run == 3, "R3 flit gap", 64'(run), 64'(3));
            run = 0;
         end
      end
   end

   task automatic send_flit();
      for (int i = 0; i < 3; i++) begin
         logic [33:0] w;
         w = rand_word();
         @(negedge wr_clk);
         wr_valid = 1'b1; wr_word = w;
         exp_q.push_back(w);
      end
      @(negedge wr_clk) wr_valid = 1'b0;
   endtask

   task automatic idle_wr(input int n);
      repeat (n) @(negedge wr_clk) wr_valid = 1'b0;
   endtask

   task automatic drain();
      int t = 0;
      while (exp_q.size() != 0 && t < 200) begin @(negedge rd_clk); t++; end
      repeat (6) @(negedge rd_clk);
   endtask

   task automatic full_reset();
      wr_rst_n = 1'b0; rd_rst_n = 1'b0;
      repeat (4) @(negedge rd_clk);
      wr_rst_n = 1'b1; rd_rst_n = 1'b1;
      repeat (2) @(negedge rd_clk);
   endtask

   initial begin
      void'($urandom(32'd4711));
      repeat (4) @(negedge rd_clk);
      // R8: values while reset is held
      check(rx_valid == 0, "R8 rx_valid in reset", 64'(rx_valid), 64'(0));
      check(err_overflow == 0 && err_underflow == 0, "R8 flags in reset",
            64'({err_overflow, err_underflow}), 64'(0));
      wr_rst_n = 1'b1; rd_rst_n = 1'b1;
      repeat (3) @(negedge rd_clk);
      check(rx_valid == 0, "R8 rx_valid after reset", 64'(rx_valid), 64'(0));

      // R5: idle slots keep rx_valid low
      begin
         int v0 = vcount;
         repeat (30) @(negedge rd_clk);
         check(vcount == v0, "R5 valid during empty slots", 64'(vcount - v0), 64'(0));
      end

      // R4: single flits launched at each write phase relative to the slot grid
      for (int ph = 0; ph < 3; ph++) begin
         idle_wr(ph + 5);
         send_flit();
         drain();
      end

      // back-to-back flits, then constrained random gaps (R1, R2, R3)
      for (int i = 0; i < 4; i++) send_flit();
      for (int i = 0; i < 60; i++) begin
         idle_wr(int'($urandom_range(0, 4)));
         send_flit();
      end
      drain();
      check(exp_q.size() == 0, "R1 words left undelivered", 64'(exp_q.size()), 64'(0));
      check(err_overflow == 0, "R6 no overflow in normal traffic", 64'(err_overflow), 64'(0));
      check(err_underflow == 0, "R7 no underflow in normal traffic", 64'(err_underflow), 64'(0));

      // R6 / R9 / R7: reader held in reset, writer overfills by one
      full_reset();
      rd_rst_n = 1'b0;
      for (int i = 0; i < 9; i++) begin
         logic [33:0] w;
         w = rand_word();
         @(negedge wr_clk);
         wr_valid = 1'b1; wr_word = w;
         if (i < 8) exp_q.push_back(w);
      end
      @(negedge wr_clk) wr_valid = 1'b0;
      repeat (3) @(negedge wr_clk);
      check(err_overflow == 1, "R6 overflow flag", 64'(err_overflow), 64'(1));
      check(rx_valid == 0, "R8 rx_valid while reader in reset", 64'(rx_valid), 64'(0));
      allow_short = 1'b1;
      @(negedge rd_clk) rd_rst_n = 1'b1;
      repeat (30) @(negedge rd_clk);
      check(exp_q.size() == 0, "R9 exactly DEPTH words kept", 64'(exp_q.size()), 64'(0));
      check(err_underflow == 1, "R7 underflow flag", 64'(err_underflow), 64'(1));
      check(err_overflow == 1, "R6 overflow flag sticky", 64'(err_overflow), 64'(1));
      allow_short = 1'b0;

      full_reset();
      check(err_overflow == 0 && err_underflow == 0, "R8 flags cleared by reset",
            64'({err_overflow, err_underflow}), 64'(0));
      send_flit();
      drain();
      check(exp_q.size() == 0, "R1 flit after recovery", 64'(exp_q.size()), 64'(0));

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule